// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Scalar Multiplier

This block computes the scalar multiple kP of a point on a non-supersingular elliptic curve over GF(2^M). It works only on x-coordinates in projective form. The caller supplies three values: the scalar `key`, the affine x-coordinate `x_in` of the base point, and the curve constant `c_in`. The constant is defined so that its square is the curve coefficient b. The caller then pulses `start`. The block copies all three values into internal registers on the start cycle and raises `busy`. It then walks the scalar from bit NBITS-2 down to bit 0; the most significant bit is taken to be 1 and is not read.

Each scalar bit costs a fixed three-cycle step. Within a step, two field multipliers run side by side and carry out one combined add-and-double. Squarers and XOR adders sit around the multipliers. The scalar bit does not change the schedule. It only chooses which register pair is the addition target and which pair is doubled. When the last step ends, `done` pulses for one cycle. The projective pair (X1,Z1) and the pair (X2,Z2) stay on the outputs until the next accepted start. Converting them to affine form and recovering y are left to the consumer.

Field elements are M-bit polynomials over GF(2), taken modulo x^M + POLY(x). With the default values, M=7 and POLY=7'h03, which is the trinomial x^7+x+1.

Top module: `ladder_kp`

## Requirements
- R1: During and after synchronous active-low reset, busy and done are 0 and all four outputs are 0.
- R2: A start seen while busy is 0 copies key, x_in and c_in into the block and raises busy on the next cycle. At that point the outputs read X1=x, Z1=1, X2=x^4+c^2 and Z2=x^2.
- R3: done is high for exactly one cycle. That cycle follows the accepting clock edge by 3*(NBITS-1) edges, and busy is 0 in the same cycle.
- R4: For a key bit of 1, one step replaces (X1,Z1) with (x·(P+Q)^2 + P·Q, (P+Q)^2), where P=X1·Z2 and Q=Z1·X2. The same step replaces (X2,Z2) with (X2^4 + c^2·Z2^4, X2^2·Z2^2). All products are taken modulo x^M + POLY.
- R5: For a key bit of 0, the same formulas apply with the pairs exchanged. (X2,Z2) receives the addition result and (X1,Z1) is doubled.
- R6: Key bit NBITS-1 has no effect on the result.
- R7: A start that arrives while busy is 1 is ignored. The result and the timing of done are those of the operation already running.
- R8: After done, the four outputs stay unchanged until the next accepted start.
- R9: Changes on key, x_in or c_in after the accepting cycle have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| key | input | NBITS | Scalar; top bit assumed 1 |
| x_in | input | M | Affine x of base point |
| c_in | input | M | Curve constant, c^2 = b |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| x1_o | output | M | Projective X1 |
| z1_o | output | M | Projective Z1 |
| x2_o | output | M | Projective X2 |
| z2_o | output | M | Projective Z2 |

## Verification
Several scalar patterns are used. An all-ones key runs only the bit-1 routing and a key with only its top bit set runs only the bit-0 routing; each can fail on its own if the swap is wired wrongly. Mixed keys check that the routing is chosen again on every step. A pair of keys that differ only in the top bit shows that the bit is never read. One run changes all inputs and pulses start again while busy, which separates correct input latching from the case where the block reads live inputs or restarts.

// File: rtl/ladder_pkg.sv
// Shared types for the ladder multiplier.
// Assumes nothing beyond a three-phase step schedule.
package ladder_pkg;
    // Phase within one ladder step: cross products, doubling, sum.
    typedef enum logic [1:0] {
        PH_CROSS  = 2'd0,
        PH_DOUBLE = 2'd1,
        PH_SUM    = 2'd2
    } phase_t;
endpackage

// File: rtl/gf_mul.sv
// Combinational GF(2^M) multiplier, polynomial basis.
// Assumes the modulus is x^M + POLY with POLY of degree below M.
// Processes b from its top bit down, reducing after each shift.
module gf_mul #(
    parameter int M = 7,
    parameter logic [M-1:0] POLY = 7'h03
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] p
);
    // Shift-and-add with interleaved reduction.
    always_comb begin
        logic [M-1:0] acc;
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
            if (b[i]) acc = acc ^ a;
        end
        p = acc;
    end
endmodule

// File: rtl/gf_sqr.sv
// Combinational GF(2^M) squarer.
// Spreads input bits to even positions, then folds the upper part
// down using x^M = POLY. Assumes POLY has degree below M.
module gf_sqr #(
    parameter int M = 7,
    parameter logic [M-1:0] POLY = 7'h03
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] q
);
    localparam int W = 2 * M - 1;

    // Interleave with zeros, then reduce from the top down.
    always_comb begin
        logic [W-1:0] w;
        w = '0;
        for (int i = 0; i < M; i++) w[2*i] = a[i];
        for (int j = W - 1; j >= M; j--) begin
            if (w[j]) begin
                w[j] = 1'b0;
                w[j-M +: M] = w[j-M +: M] ^ POLY;
            end
        end
        q = w[M-1:0];
    end
endmodule

// File: rtl/ladder_ctrl.sv
// Sequencer for the ladder: accepts start while idle, latches the
// scalar, and steps the bit index from NBITS-2 down to 0 with three
// phases per bit. Pulses done after the final phase.
// Assumes NBITS >= 2.
module ladder_ctrl
    import ladder_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] key,
    output logic             busy,
    output logic             done,
    output logic             load,
    output phase_t           phase,
    output logic             cur_bit
);
    localparam int IW = (NBITS > 2) ? $clog2(NBITS) : 1;

    logic [NBITS-1:0] key_q;
    logic [IW-1:0]    idx;

    assign load    = start && !busy;
    assign cur_bit = key_q[idx];

    // Phase/bit counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= PH_CROSS;
            idx   <= '0;
            key_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    key_q <= key;
                    idx   <= IW'(NBITS - 2);
                    phase <= PH_CROSS;
                    busy  <= 1'b1;
                end
            end else begin
                case (phase)
                    PH_CROSS:  phase <= PH_DOUBLE;
                    PH_DOUBLE: phase <= PH_SUM;
                    default: begin
                        phase <= PH_CROSS;
                        if (idx == '0) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ladder_dp.sv
// Ladder datapath: four coordinate registers, the latched base x and
// constant c, two product registers, two field multipliers and the
// squarers around them. The key bit picks which pair is the addition
// target (a) and which is doubled (d); the schedule is fixed:
//   CROSS : P = Xa*Zd, Q = Za*Xd
//   DOUBLE: Zd = Xd^2*Zd^2, Xd = Xd^4 + (c*Zd^2)^2
//   SUM   : Xa = P*Q + x*(P+Q)^2, Za = (P+Q)^2
module ladder_dp
    import ladder_pkg::*;
#(
    parameter int M = 7,
    parameter logic [M-1:0] POLY = 7'h03
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  phase_t       phase,
    input  logic         cur_bit,
    input  logic [M-1:0] x_in,
    input  logic [M-1:0] c_in,
    output logic [M-1:0] x1,
    output logic [M-1:0] z1,
    output logic [M-1:0] x2,
    output logic [M-1:0] z2
);
    logic [M-1:0] xb, cb, pr, qr;
    logic [M-1:0] xa, za, xd, zd;
    logic [M-1:0] s_sq, t_sq, s_4, ct_sq, pq_sq;
    logic [M-1:0] xi_sq, xi_4, ci_sq;
    logic [M-1:0] m1_a, m1_b, m1_p, m2_a, m2_b, m2_p;

    // Role selection by the current key bit.
    always_comb begin
        xa = cur_bit ? x1 : x2;
        za = cur_bit ? z1 : z2;
        xd = cur_bit ? x2 : x1;
        zd = cur_bit ? z2 : z1;
    end

    gf_sqr #(.M(M), .POLY(POLY)) u_sq_s  (.a(xd),      .q(s_sq));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_t  (.a(zd),      .q(t_sq));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_s4 (.a(s_sq),    .q(s_4));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_ct (.a(m2_p),    .q(ct_sq));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_pq (.a(pr ^ qr), .q(pq_sq));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_x  (.a(x_in),    .q(xi_sq));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_x4 (.a(xi_sq),   .q(xi_4));
    gf_sqr #(.M(M), .POLY(POLY)) u_sq_c  (.a(c_in),    .q(ci_sq));

    // Multiplier operand routing per phase.
    always_comb begin
        case (phase)
            PH_CROSS: begin
                m1_a = xa;   m1_b = zd;
                m2_a = za;   m2_b = xd;
            end
            PH_DOUBLE: begin
                m1_a = s_sq; m1_b = t_sq;
                m2_a = t_sq; m2_b = cb;
            end
            default: begin
                m1_a = pr;   m1_b = qr;
                m2_a = xb;   m2_b = pq_sq;
            end
        endcase
    end

    gf_mul #(.M(M), .POLY(POLY)) u_mul1 (.a(m1_a), .b(m1_b), .p(m1_p));
    gf_mul #(.M(M), .POLY(POLY)) u_mul2 (.a(m2_a), .b(m2_b), .p(m2_p));

    // Register updates: initial load, then per-phase write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xb <= '0; cb <= '0; pr <= '0; qr <= '0;
            x1 <= '0; z1 <= '0; x2 <= '0; z2 <= '0;
        end else if (load) begin
            xb <= x_in;
            cb <= c_in;
            x1 <= x_in;
            z1 <= M'(1);
            x2 <= xi_4 ^ ci_sq;
            z2 <= xi_sq;
        end else if (run) begin
            case (phase)
                PH_CROSS: begin
                    pr <= m1_p;
                    qr <= m2_p;
                end
                PH_DOUBLE: begin
                    if (cur_bit) begin
                        z2 <= m1_p;
                        x2 <= s_4 ^ ct_sq;
                    end else begin
                        z1 <= m1_p;
                        x1 <= s_4 ^ ct_sq;
                    end
                end
                default: begin
                    if (cur_bit) begin
                        x1 <= m1_p ^ m2_p;
                        z1 <= pq_sq;
                    end else begin
                        x2 <= m1_p ^ m2_p;
                        z2 <= pq_sq;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ladder_kp.sv
// Top of the x-only Montgomery ladder scalar multiplier over GF(2^M).
// Latches key, x and c on an accepted start, runs NBITS-1 three-cycle
// steps and pulses done. Assumes the key's top bit is 1.
module ladder_kp
    import ladder_pkg::*;
#(
    parameter int M = 7,
    parameter logic [M-1:0] POLY = 7'h03,
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] key,
    input  logic [M-1:0]     x_in,
    input  logic [M-1:0]     c_in,
    output logic             busy,
    output logic             done,
    output logic [M-1:0]     x1_o,
    output logic [M-1:0]     z1_o,
    output logic [M-1:0]     x2_o,
    output logic [M-1:0]     z2_o
);
    logic   load, cur_bit;
    phase_t phase;

    ladder_ctrl #(.NBITS(NBITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .busy(busy), .done(done), .load(load),
        .phase(phase), .cur_bit(cur_bit)
    );

    ladder_dp #(.M(M), .POLY(POLY)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .run(busy),
        .phase(phase), .cur_bit(cur_bit),
        .x_in(x_in), .c_in(c_in),
        .x1(x1_o), .z1(z1_o), .x2(x2_o), .z2(z2_o)
    );
endmodule

// File: rtl/ladder_kp_chk.sv
// Protocol checker for ladder_kp: handshake, latency, hold behaviour.
// Counts cycles of a run itself so no long $past window is needed.
module ladder_kp_chk #(
    parameter int M = 7,
    parameter int NBITS = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] x1_o,
    input logic [M-1:0] z1_o,
    input logic [M-1:0] x2_o,
    input logic [M-1:0] z2_o
);
    localparam int LAT = 3 * (NBITS - 1);

    logic [31:0] run_cnt;

    // Edges elapsed since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cnt <= '0;
        else if (start && !busy)   run_cnt <= '0;
        else if (busy)             run_cnt <= run_cnt + 1;
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == LAT));
    a_r3_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_accept_init: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && z1_o == M'(1)));
    a_r7_run_uninterrupted: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt < LAT - 1) |=> busy);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(x1_o) && $stable(z1_o) &&
                                     $stable(x2_o) && $stable(z2_o)));
endmodule

bind ladder_kp ladder_kp_chk #(.M(M), .NBITS(NBITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .x1_o(x1_o), .z1_o(z1_o), .x2_o(x2_o), .z2_o(z2_o)
);

// File: tb/sim_ladder_kp.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes reference results, the monitor
// pops and compares them when done pulses.
module sim_ladder_kp;
    localparam int M = 7;
    localparam logic [M-1:0] POLY = 7'h03;
    localparam int NB = 8;
    localparam int LAT = 3 * (NB - 1);

    typedef struct {
        logic [M-1:0] x1, z1, x2, z2;
        int           t0;
    } item_t;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [NB-1:0] key = '0;
    logic [M-1:0]  x_in = '0, c_in = '0;
    logic          busy, done;
    logic [M-1:0]  x1_o, z1_o, x2_o, z2_o;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    item_t sb[$];

    ladder_kp #(.M(M), .POLY(POLY), .NBITS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .x_in(x_in), .c_in(c_in), .busy(busy), .done(done),
        .x1_o(x1_o), .z1_o(z1_o), .x2_o(x2_o), .z2_o(z2_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference field product: full polynomial product, then fold.
    function automatic logic [M-1:0] fmul(logic [M-1:0] a, logic [M-1:0] b);
        logic [2*M-2:0] pr;
        pr = '0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                pr[i+j] = pr[i+j] ^ (a[i] & b[j]);
        for (int k = 2 * M - 2; k >= M; k--)
            if (pr[k]) begin
                pr[k] = 1'b0;
                for (int t = 0; t < M; t++)
                    pr[k-M+t] = pr[k-M+t] ^ POLY[t];
            end
        return pr[M-1:0];
    endfunction

    function automatic item_t ref_ladder(logic [NB-1:0] k, logic [M-1:0] x,
                                         logic [M-1:0] c);
        item_t r;
        logic [M-1:0] ax, az, dx, dz, p, q, s, t, u;
        r.x1 = x; r.z1 = M'(1);
        r.x2 = fmul(fmul(x, x), fmul(x, x)) ^ fmul(c, c);
        r.z2 = fmul(x, x);
        for (int i = NB - 2; i >= 0; i--) begin
            ax = k[i] ? r.x1 : r.x2;  az = k[i] ? r.z1 : r.z2;
            dx = k[i] ? r.x2 : r.x1;  dz = k[i] ? r.z2 : r.z1;
            p = fmul(ax, dz); q = fmul(az, dx);
            u = fmul(p ^ q, p ^ q);
            ax = fmul(x, u) ^ fmul(p, q); az = u;
            s = fmul(dx, dx); t = fmul(dz, dz);
            dz = fmul(s, t);
            dx = fmul(s, s) ^ fmul(fmul(c, t), fmul(c, t));
            if (k[i]) begin r.x1 = ax; r.z1 = az; r.x2 = dx; r.z2 = dz; end
            else      begin r.x2 = ax; r.z2 = az; r.x1 = dx; r.z1 = dz; end
        end
        r.t0 = 0;
        return r;
    endfunction

    // Monitor: compare result and latency on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R3 unexpected done", 1, 0);
            end else begin
                item_t e;
                e = sb.pop_front();
                chk("R3 latency", cyc - e.t0, LAT + 1);
                chk("R4/R5 x1", x1_o, e.x1);
                chk("R4/R5 z1", z1_o, e.z1);
                chk("R4/R5 x2", x2_o, e.x2);
                chk("R4/R5 z2", z2_o, e.z2);
                chk("R3 busy low at done", busy, 0);
            end
        end
    end

    // Driver: one operation, optional disturbance, then hold check.
    task automatic run_op(string tag, logic [NB-1:0] k, logic [M-1:0] x,
                          logic [M-1:0] c, bit disturb);
        item_t e;
        e = ref_ladder(k, x, c);
        @(negedge clk);
        e.t0 = cyc;
        sb.push_back(e);
        key = k; x_in = x; c_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R2 busy"}, busy, 1);
        chk({tag, " R2 init X1"}, x1_o, x);
        chk({tag, " R2 init Z1"}, z1_o, 1);
        chk({tag, " R2 init X2"}, x2_o, fmul(fmul(x, x), fmul(x, x)) ^ fmul(c, c));
        chk({tag, " R2 init Z2"}, z2_o, fmul(x, x));
        if (disturb) begin
            // R9: inputs change; R7: start pulsed while busy.
            key = ~k; x_in = x ^ 7'h5A; c_in = c ^ 7'h33;
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            key = 8'h3C; x_in = 7'h11;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        chk({tag, " R3 done one cycle"}, done, 0);
        repeat (5) @(negedge clk);
        chk({tag, " R8 hold X1"}, x1_o, e.x1);
        chk({tag, " R8 hold Z2"}, z2_o, e.z2);
        chk({tag, " R8 idle"}, busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 outputs", {x1_o, z1_o, x2_o, z2_o}, 0);
        rst_n = 1'b1;
        run_op("ones R4", 8'hFF, 7'h35, 7'h12, 0);
        run_op("top-only R5", 8'h80, 7'h4B, 7'h07, 0);
        run_op("mixed R4 R5", 8'hA5, 7'h1D, 7'h66, 0);
        run_op("mixed2 R4 R5", 8'hD2, 7'h7F, 7'h01, 0);
        run_op("top1 R6", 8'hAB, 7'h29, 7'h3E, 0);
        run_op("top0 R6", 8'h2B, 7'h29, 7'h3E, 0);
        run_op("disturb R7 R9", 8'hC6, 7'h58, 7'h24, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule